// File: doc/BRIEF.md
# User-Mode Dummy-Cycle Snooper

This block sits between the software-driven byte stream of a serial flash controller running in user mode and the shift engine that clocks bytes onto the flash bus. Software writes a command, an address and a placeholder byte for each access. The snooper recognises read commands that need dummy cycles before data. At that point it produces the dummy bytes itself and drops the placeholder byte that software wrote.

Tracking restarts each time the chip select goes active. The first accepted byte is taken as the command. Commands that need no dummy phase switch tracking off for the rest of the selection. For a command that does need a dummy phase, the block lets the command and the address bytes through, where the address is 3 or 4 bytes wide as set by the address-width input. The next byte after the address triggers a burst of dummy bytes. Each dummy byte carries the current dummy-data value. The input stalls until the burst is over. After the burst, tracking is off until the next selection.

Top module: `user_dummy_snooper`

## Requirements
- R1: During and right after reset, `out_valid` and `consumed` are 0 and `in_ready` is 1.
- R2: While `cs_active` is 0, every accepted byte (`in_valid` and `in_ready` both 1) appears on `out_byte` with `out_valid`=1 and `out_dummy`=0 exactly one cycle later, whatever its value.
- R3: When the first byte after selection is the plain read 0x03 or any code outside the R4 list, it and every later byte of that selection are forwarded, and no dummy byte is inserted.
- R4: The codes 0x0B, 0x0C, 0x3B, 0x3C, 0x6B, 0x6C, 0xBB, 0xBC, 0xEB and 0xEC, when sent as the first byte after selection, arm insertion. The byte accepted after the command and its address bytes is not forwarded. Instead, `consumed` pulses high for one cycle, one cycle after that byte is accepted, with `out_valid`=0.
- R5: After the `consumed` pulse come exactly 8 consecutive cycles with `out_valid`=1, `out_dummy`=1 and `out_byte` equal to `dummy_value`.
- R6: `in_ready` is 0 from the `consumed` pulse until the last dummy byte is on the output. A byte held on the input during that time is accepted only afterwards and is forwarded unchanged.
- R7: Once the dummy bytes have been sent, later bytes of the same selection are forwarded unchanged. This includes any byte whose value is on the R4 list.
- R8: With `addr4`=0 the address phase is 3 bytes; with `addr4`=1 it is 4 bytes.
- R9: Dropping `cs_active` cancels tracking and any dummy bytes not yet sent: on the next cycle `out_valid` is 0 and `in_ready` is 1. The next selection starts over at the command byte.
- R10: The command byte and the address bytes of an armed access are forwarded unchanged, one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_active | input | 1 | Chip select asserted (level) |
| addr4 | input | 1 | 1 selects a 4-byte address phase, 0 a 3-byte one |
| dummy_value | input | 8 | Byte sent for each inserted dummy |
| in_valid | input | 1 | Software byte present |
| in_byte | input | 8 | Software byte |
| in_ready | output | 1 | Byte accepted this cycle when in_valid is also 1 |
| out_valid | output | 1 | Byte for the shift engine valid |
| out_byte | output | 8 | Byte for the shift engine |
| out_dummy | output | 1 | Current output byte is an inserted dummy |
| consumed | output | 1 | A placeholder byte was swallowed |

## Verification
The assertions assume that the input byte stays stable while `in_valid` is held against a low `in_ready`. They also assume that `dummy_value` and `addr4` are not changed in the middle of an access. The bench changes these configuration inputs only while the chip select is inactive or between tests. It holds a blocked byte steady across the whole burst, and it deselects mid-burst only in the test meant to check cancellation.

// File: rtl/uds_pkg.sv
package uds_pkg;

    localparam int IDX_W = 8;
    typedef logic [IDX_W-1:0] idx_t;

    // Tracking index: all ones = idle, zero = expecting the command byte
    localparam idx_t IDX_OFF   = '1;
    localparam idx_t IDX_START = '0;

    typedef enum logic [1:0] {
        CLS_NONE,   // no dummy phase
        CLS_OUT,    // fast / dual-output / quad-output reads
        CLS_IO      // dual-I/O / quad-I/O reads
    } cmd_class_e;

    typedef enum logic [1:0] {
        BEAT_IDLE,
        BEAT_FWD,
        BEAT_DUMMY
    } beat_kind_e;

    typedef struct packed {
        beat_kind_e kind;
        logic [7:0] data;
    } beat_t;

    function automatic cmd_class_e classify(input logic [7:0] cmd);
        case (cmd)
            8'h0B, 8'h0C, 8'h3B, 8'h3C, 8'h6B, 8'h6C: return CLS_OUT;
            8'hBB, 8'hBC, 8'hEB, 8'hEC:               return CLS_IO;
            default:                                  return CLS_NONE;
        endcase
    endfunction

    function automatic idx_t addr_bytes(input logic wide);
        return wide ? idx_t'(4) : idx_t'(3);
    endfunction

endpackage

// File: rtl/uds_cmd_decode.sv
module uds_cmd_decode
    import uds_pkg::*;
#(
    parameter int OUT_UNITS = 1,
    parameter int IO_UNITS  = 1,
    parameter int UNIT_W    = 1
) (
    input  logic [7:0]        cmd,
    output logic [UNIT_W-1:0] units
);
    cmd_class_e cls;

    always_comb begin
        cls = classify(cmd);
        case (cls)
            CLS_OUT: units = UNIT_W'(OUT_UNITS);
            CLS_IO:  units = UNIT_W'(IO_UNITS);
            default: units = '0;
        endcase
    end
endmodule

// File: rtl/uds_tracker.sv
module uds_tracker
    import uds_pkg::*;
#(
    parameter int UNIT_W      = 1,
    parameter int CNT_W       = 4,
    parameter int DUMMY_SCALE = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_active,
    input  logic              addr4,
    input  logic              take,
    input  logic [UNIT_W-1:0] units,
    output logic              swallow,
    output logic [CNT_W-1:0]  burst_len
);
    idx_t             idx_q, idx_d, eff_idx;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cs_q;

    always_comb begin
        // A fresh selection restarts at the command byte in the same cycle
        eff_idx = (cs_active && !cs_q) ? IDX_START : idx_q;
        idx_d   = eff_idx;
        cnt_d   = cnt_q;
        swallow = 1'b0;
        if (!cs_active) begin
            idx_d = IDX_OFF;
            cnt_d = '0;
        end else if (take && eff_idx != IDX_OFF) begin
            if (eff_idx == IDX_START) begin
                if (units == '0) begin
                    idx_d = IDX_OFF;
                end else begin
                    cnt_d = CNT_W'(int'(units) * DUMMY_SCALE);
                    idx_d = eff_idx + idx_t'(1);
                end
            end else if (eff_idx >= addr_bytes(addr4) + idx_t'(1)) begin
                swallow = 1'b1;
                idx_d   = IDX_OFF;
                cnt_d   = '0;
            end else begin
                idx_d = eff_idx + idx_t'(1);
            end
        end
    end

    assign burst_len = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= IDX_OFF;
            cnt_q <= '0;
            cs_q  <= 1'b0;
        end else begin
            idx_q <= idx_d;
            cnt_q <= cnt_d;
            cs_q  <= cs_active;
        end
    end
endmodule

// File: rtl/uds_emitter.sv
module uds_emitter
    import uds_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_active,
    input  logic             take,
    input  logic [7:0]       in_byte,
    input  logic             swallow,
    input  logic [CNT_W-1:0] burst_len,
    input  logic [7:0]       dummy_value,
    output logic             in_ready,
    output logic             out_valid,
    output logic [7:0]       out_byte,
    output logic             out_dummy,
    output logic             consumed
);
    logic [CNT_W-1:0] rem_q;
    beat_t            beat_q;
    logic             cons_q;

    assign in_ready  = (rem_q == '0);
    assign out_valid = (beat_q.kind != BEAT_IDLE);
    assign out_dummy = (beat_q.kind == BEAT_DUMMY);
    assign out_byte  = beat_q.data;
    assign consumed  = cons_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            beat_q <= '{kind: BEAT_IDLE, data: 8'h00};
            cons_q <= 1'b0;
        end else begin
            cons_q <= take && swallow;
            if (rem_q != '0) begin
                if (cs_active) begin
                    beat_q <= '{kind: BEAT_DUMMY, data: dummy_value};
                    rem_q  <= rem_q - CNT_W'(1);
                end else begin
                    beat_q.kind <= BEAT_IDLE;
                    rem_q       <= '0;
                end
            end else if (take && swallow) begin
                beat_q.kind <= BEAT_IDLE;
                rem_q       <= burst_len;
            end else if (take) begin
                beat_q <= '{kind: BEAT_FWD, data: in_byte};
            end else begin
                beat_q.kind <= BEAT_IDLE;
            end
        end
    end
endmodule

// File: rtl/user_dummy_snooper.sv
module user_dummy_snooper #(
    parameter int OUT_UNITS   = 1,
    parameter int IO_UNITS    = 1,
    parameter int DUMMY_SCALE = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_active,
    input  logic       addr4,
    input  logic [7:0] dummy_value,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       in_ready,
    output logic       out_valid,
    output logic [7:0] out_byte,
    output logic       out_dummy,
    output logic       consumed
);
    localparam int MAX_UNITS = (OUT_UNITS > IO_UNITS) ? OUT_UNITS : IO_UNITS;
    localparam int UNIT_W    = $clog2(MAX_UNITS + 1);
    localparam int CNT_W     = $clog2(MAX_UNITS * DUMMY_SCALE + 1);

    logic              take;
    logic              swallow;
    logic [UNIT_W-1:0] units;
    logic [CNT_W-1:0]  burst_len;

    assign take = in_valid && in_ready;

    uds_cmd_decode #(
        .OUT_UNITS (OUT_UNITS),
        .IO_UNITS  (IO_UNITS),
        .UNIT_W    (UNIT_W)
    ) u_decode (
        .cmd   (in_byte),
        .units (units)
    );

    uds_tracker #(
        .UNIT_W      (UNIT_W),
        .CNT_W       (CNT_W),
        .DUMMY_SCALE (DUMMY_SCALE)
    ) u_tracker (
        .clk       (clk),
        .rst       (rst),
        .cs_active (cs_active),
        .addr4     (addr4),
        .take      (take),
        .units     (units),
        .swallow   (swallow),
        .burst_len (burst_len)
    );

    uds_emitter #(
        .CNT_W (CNT_W)
    ) u_emitter (
        .clk         (clk),
        .rst         (rst),
        .cs_active   (cs_active),
        .take        (take),
        .in_byte     (in_byte),
        .swallow     (swallow),
        .burst_len   (burst_len),
        .dummy_value (dummy_value),
        .in_ready    (in_ready),
        .out_valid   (out_valid),
        .out_byte    (out_byte),
        .out_dummy   (out_dummy),
        .consumed    (consumed)
    );
endmodule

// File: rtl/uds_checker.sv
module uds_checker (
    input logic       clk,
    input logic       rst,
    input logic       cs_active,
    input logic [7:0] dummy_value,
    input logic       in_valid,
    input logic [7:0] in_byte,
    input logic       in_ready,
    input logic       out_valid,
    input logic [7:0] out_byte,
    input logic       out_dummy,
    input logic       consumed
);
    logic rst_seen;

    always_ff @(posedge clk) rst_seen <= rst;

    always @(posedge clk) begin
        if (rst_seen) begin
            assert_reset_idle_R1: assert (!out_valid && !consumed && in_ready);
        end
    end

    assert_pass_deselected_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !cs_active) |=>
            (out_valid && !out_dummy && out_byte == $past(in_byte)));

    assert_swallow_silent_R4: assert property (@(posedge clk) disable iff (rst)
        consumed |-> !out_valid);

    assert_swallow_single_R4: assert property (@(posedge clk) disable iff (rst)
        consumed |=> !consumed);

    assert_dummy_value_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_dummy) |-> (out_byte == $past(dummy_value)));

    assert_burst_stall_R6: assert property (@(posedge clk) disable iff (rst)
        consumed |-> !in_ready);

    assert_stall_emits_R6: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && cs_active) |=> (out_valid && out_dummy));

    assert_cancel_R9: assert property (@(posedge clk) disable iff (rst)
        (!cs_active && !in_ready) |=> (in_ready && !out_valid));
endmodule

bind user_dummy_snooper uds_checker i_uds_checker (
    .clk         (clk),
    .rst         (rst),
    .cs_active   (cs_active),
    .dummy_value (dummy_value),
    .in_valid    (in_valid),
    .in_byte     (in_byte),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_byte    (out_byte),
    .out_dummy   (out_dummy),
    .consumed    (consumed)
);

// File: tb/test_user_dummy_snooper.sv
`timescale 1ns/1ps
module test_user_dummy_snooper;
    logic       clk = 1'b0;
    logic       rst;
    logic       cs_active;
    logic       addr4;
    logic [7:0] dummy_value;
    logic       in_valid;
    logic [7:0] in_byte;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_byte;
    logic       out_dummy;
    logic       consumed;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    user_dummy_snooper i_user_dummy_snooper (
        .clk(clk), .rst(rst), .cs_active(cs_active), .addr4(addr4),
        .dummy_value(dummy_value), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .out_valid(out_valid), .out_byte(out_byte),
        .out_dummy(out_dummy), .consumed(consumed)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive one byte, then look at the output one cycle after acceptance
    task automatic push_fwd(input logic [7:0] b, input string req);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && !out_dummy && !consumed && out_byte == b, req,
              "forwarded byte", {out_valid, out_dummy, consumed, out_byte},
              {3'b100, b});
    endtask

    task automatic set_cs(input logic v);
        @(negedge clk);
        cs_active = v;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(!out_valid && !consumed && in_ready, "R1", "reset state",
              {out_valid, consumed, in_ready}, 3'b001);
    endtask

    task automatic t_deselected;
        set_cs(1'b0);
        push_fwd(8'h0B, "R2");
        push_fwd(8'hEB, "R2");
        push_fwd(8'h37, "R2");
    endtask

    task automatic t_no_dummy(input logic [7:0] cmd);
        set_cs(1'b1);
        push_fwd(cmd, "R3");
        for (int i = 0; i < 8; i++) push_fwd(8'h10 + 8'(i), "R3");
        set_cs(1'b0);
    endtask

    // Armed access: command, address, placeholder, then the dummy burst
    task automatic t_armed(input logic [7:0] cmd, input logic wide,
                           input logic [7:0] dv);
        int naddr;
        naddr = wide ? 4 : 3;
        @(negedge clk);
        addr4       = wide;
        dummy_value = dv;
        set_cs(1'b1);
        push_fwd(cmd, "R10");
        for (int i = 0; i < naddr; i++) push_fwd(8'hA0 + 8'(i), wide ? "R8" : "R10");
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = 8'hC3;
        @(negedge clk);
        in_byte = 8'h5A;   // held through the burst
        check(consumed && !out_valid, wide ? "R8" : "R4", "placeholder swallowed",
              {consumed, out_valid}, 2'b10);
        check(!in_ready, "R6", "stall at swallow", in_ready, 0);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            check(out_valid && out_dummy && out_byte == dv && !consumed, "R5",
                  "dummy byte", {out_valid, out_dummy, out_byte}, {2'b11, dv});
            check(in_ready == (k == 8), "R6", "stall window", in_ready, k == 8);
        end
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && !out_dummy && out_byte == 8'h5A, "R6",
              "held byte after burst", {out_valid, out_dummy, out_byte}, {2'b10, 8'h5A});
        for (int i = 0; i < 6; i++) push_fwd(8'h0B, "R7");
        set_cs(1'b0);
    endtask

    task automatic t_restart;
        addr4 = 1'b0;
        set_cs(1'b1);
        push_fwd(8'h0B, "R9");
        push_fwd(8'h01, "R9");
        push_fwd(8'h02, "R9");
        set_cs(1'b0);
        set_cs(1'b1);
        push_fwd(8'h03, "R9");
        for (int i = 0; i < 5; i++) push_fwd(8'h20 + 8'(i), "R9");
        set_cs(1'b0);
    endtask

    task automatic t_cancel;
        addr4       = 1'b0;
        dummy_value = 8'h3C;
        set_cs(1'b1);
        push_fwd(8'hBB, "R10");
        for (int i = 0; i < 3; i++) push_fwd(8'h40 + 8'(i), "R10");
        push_fwd_expect_swallow();
        @(negedge clk);
        @(negedge clk);
        check(out_valid && out_dummy && out_byte == 8'h3C, "R5", "dummy before cancel",
              {out_valid, out_dummy, out_byte}, {2'b11, 8'h3C});
        cs_active = 1'b0;
        @(negedge clk);
        check(!out_valid && in_ready, "R9", "burst cancelled",
              {out_valid, in_ready}, 2'b01);
        @(negedge clk);
        check(!out_valid && in_ready, "R9", "stays idle", {out_valid, in_ready}, 2'b01);
    endtask

    task automatic push_fwd_expect_swallow;
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = 8'hFF;
        @(negedge clk);
        in_valid = 1'b0;
        check(consumed && !out_valid, "R4", "swallow in cancel test",
              {consumed, out_valid}, 2'b10);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cs_active = 1'b0; addr4 = 1'b0; dummy_value = 8'h00;
        in_valid = 1'b0; in_byte = 8'h00;
        repeat (3) @(negedge clk);
        check(!out_valid && !consumed && in_ready, "R1", "in reset",
              {out_valid, consumed, in_ready}, 3'b001);
        rst = 1'b0;
        t_reset();
        t_deselected();
        t_no_dummy(8'h03);
        t_no_dummy(8'h9F);
        t_armed(8'h0B, 1'b0, 8'hA5);
        t_armed(8'hEC, 1'b1, 8'h00);
        t_armed(8'h3B, 1'b0, 8'h77);
        t_restart();
        t_cancel();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule